// File: doc/BRIEF.md
# Speculative Update Message Generator

This block sits between a cache controller and the coherence bus of one node in a shared-memory multiprocessor. It produces and consumes speculative update hints that keep stale (invalid) copies of a line close to the current value. Later loads that read an invalid copy speculatively are then more likely to guess right, while the ordinary invalidation protocol still decides what is correct.

On the writer side, each local store that must invalidate other copies sends its invalidation on the next cycle. When the stored word is zero, one or all-ones, a two-bit value code rides along with it. The block also counts the stores made to each line since that line was last cleared. On the fifth such store it queues a broadcast that carries only the words that were written. Broadcasts wait in a small queue until the bus offers a free slot for update traffic. If the queue overflows, the oldest broadcast is thrown away, because these messages are only hints. The store port has no back-pressure.

On the receiver side, incoming messages are looked up in the local cache by line number. A piggybacked value is written into any copy that matches the line. A count-mode broadcast is written only into a copy that is already invalid. All other messages are dropped without effect.

Top module: `spec_upd_top`

## Requirements
- R1: After reset, `outValid` and `cacheWrEn` are 0.
- R2: A store with `stShared`=1 makes the cycle after it carry an invalidation: `outValid`=1, `outKind`=0, `outLine`/`outWord` equal to the store's, `outMask`=0, and `outCode` = 01 for a zero word, 10 for the value 1, 11 for all-ones, 00 for any other value.
- R3: When an invalidation and a queued broadcast compete for the same output cycle, the invalidation is sent and the broadcast waits for the next granted cycle.
- R4: The fifth store to a line since its last clear queues one broadcast. It is sent as `outKind`=1 with that line and `outMask` set for each word written. Word w of `outData` (bits w*W upward) holds the latest value stored to that word, and unmarked words are zero.
- R5: A line's store count and word mask clear when the line is broadcast, when `evValid` names it, or when an incoming invalidation (`inKind`=0) names it. After a clear, five fresh stores are needed, and the mask covers only the words stored after the clear.
- R6: A broadcast leaves the queue only in a cycle where `updGrant`=1 and no invalidation is being sent; it appears on the output the next cycle. Queued broadcasts leave oldest first.
- R7: When a broadcast is queued while the queue (depth `DEPTH`) is full and nothing leaves, the oldest queued broadcast is discarded.
- R8: `lookupLine` follows `inLine` in the same cycle. An incoming invalidation with a non-zero code and `cacheHit`=1 writes the decoded word (01→0, 10→1, 11→all-ones) the next cycle, whatever `cacheInvalid` is. The write has a one-hot mask at `inWord` and zeros in the other words. Code 00 or a miss writes nothing.
- R9: An incoming broadcast (`inKind`=1) writes its marked words the next cycle only when `cacheHit`=1 and `cacheInvalid`=1, with unmarked words zeroed. Otherwise `cacheWrEn` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stWrite | input | 1 | Local store strobe |
| stLine | input | LINE_W | Line number of the store |
| stWord | input | log2(WORDS) | Word within the line |
| stData | input | W | Stored value |
| stShared | input | 1 | Other copies exist, so an invalidation is needed |
| evValid | input | 1 | Local line eviction strobe |
| evLine | input | LINE_W | Evicted line |
| updGrant | input | 1 | Bus offers a slot for update traffic |
| outValid | output | 1 | Outgoing message valid |
| outKind | output | 1 | 0 invalidation, 1 broadcast |
| outLine | output | LINE_W | Line of outgoing message |
| outWord | output | log2(WORDS) | Word of piggybacked value |
| outCode | output | 2 | Piggybacked value code |
| outMask | output | WORDS | Words carried by a broadcast |
| outData | output | WORDS*W | Broadcast words |
| inValid | input | 1 | Incoming message valid |
| inKind | input | 1 | 0 invalidation, 1 broadcast |
| inLine | input | LINE_W | Line of incoming message |
| inWord | input | log2(WORDS) | Word of piggybacked value |
| inCode | input | 2 | Piggybacked value code |
| inMask | input | WORDS | Words carried by incoming broadcast |
| inData | input | WORDS*W | Incoming broadcast words |
| lookupLine | output | LINE_W | Line looked up in the local cache |
| cacheHit | input | 1 | Looked-up line is present |
| cacheInvalid | input | 1 | Present copy is in the invalid state |
| cacheWrEn | output | 1 | Speculative write strobe to the cache |
| cacheWrLine | output | LINE_W | Line written |
| cacheWrMask | output | WORDS | Words written |
| cacheWrData | output | WORDS*W | Write data |

## Verification
The value encoder is driven with a table of store values: zero, one and all-ones, plus near misses such as 2, all-ones minus one and a lone top bit. This shows that only exact matches earn a code. Broadcasts are tried with repeated writes to the same word, with clears by broadcast, by eviction and by a foreign invalidation, and with an invalidation colliding with a ready broadcast. These tell whether the count and the mask really restart, and whether the invalidation wins. Three broadcasts queued without grant separate dropping the oldest from dropping the newest. On the receiver side, each code is combined with hit, miss, valid and invalid copies, which separates the rule "any matching copy" from the rule "invalid copies only".

// File: rtl/spec_upd_pkg.sv
package spec_upd_pkg;
  localparam logic KIND_INV = 1'b0;
  localparam logic KIND_UPD = 1'b1;

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_ZERO = 2'b01;
  localparam logic [1:0] CODE_ONE  = 2'b10;
  localparam logic [1:0] CODE_ONES = 2'b11;

  typedef struct packed {
    logic invSend;  // emit invalidation for the current store
    logic push;     // queue a broadcast
    logic pop;      // send the oldest queued broadcast
  } upd_strobe_t;
endpackage

// File: rtl/spec_upd_ctrl.sv
module spec_upd_ctrl
  import spec_upd_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int LINE_W = 2,
  parameter int THRESH = 5,
  parameter int DEPTH  = 2,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int LINES  = 1 << LINE_W,
  localparam int CNT_W  = $clog2(THRESH + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stWrite,
  input  logic [LINE_W-1:0] stLine,
  input  logic [WIDX_W-1:0] stWord,
  input  logic              stShared,
  input  logic              evValid,
  input  logic [LINE_W-1:0] evLine,
  input  logic              snoopInv,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              updGrant,
  output upd_strobe_t       strb,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [WORDS-1:0]  pushMask
);
  logic [CNT_W-1:0] cnt  [LINES];
  logic [WORDS-1:0] mask [LINES];
  logic [OCC_W-1:0] occ;
  logic [LINES-1:0] clrVec;
  logic [CNT_W-1:0] nextCnt;
  logic storeHit, fire, drop;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    for (int i = 0; i < LINES; i++)
      clrVec[i] = (evValid && evLine == LINE_W'(i)) || (snoopInv && snoopLine == LINE_W'(i));
    storeHit     = stWrite && !clrVec[stLine];
    nextCnt      = cnt[stLine] + 1'b1;
    fire         = storeHit && (nextCnt == CNT_W'(THRESH));
    pushMask     = mask[stLine] | (WORDS'(1) << stWord);
    strb.invSend = stWrite && stShared;
    strb.push    = fire;
    strb.pop     = (occ != '0) && !strb.invSend && updGrant;
    drop         = fire && !strb.pop && (occ == OCC_W'(DEPTH));
  end

  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN || clrVec[g]) begin
        cnt[g]  <= '0;
        mask[g] <= '0;
      end else if (storeHit && stLine == LINE_W'(g)) begin
        cnt[g]  <= fire ? '0 : nextCnt;
        mask[g] <= fire ? '0 : pushMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ   <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop || drop) rdPtr <= bump(rdPtr);
      if (strb.push && !strb.pop && !drop) occ <= occ + 1'b1;
      else if (!strb.push && strb.pop) occ <= occ - 1'b1;
    end
  end
endmodule

// File: rtl/spec_upd_dp.sv
module spec_upd_dp
  import spec_upd_pkg::*;
#(
  parameter int W      = 32,
  parameter int WORDS  = 4,
  parameter int LINE_W = 2,
  parameter int DEPTH  = 2,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int LINES  = 1 << LINE_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  upd_strobe_t         strb,
  input  logic [PTR_W-1:0]    wrPtr,
  input  logic [PTR_W-1:0]    rdPtr,
  input  logic [WORDS-1:0]    pushMask,
  input  logic                stWrite,
  input  logic [LINE_W-1:0]   stLine,
  input  logic [WIDX_W-1:0]   stWord,
  input  logic [W-1:0]        stData,
  output logic                outValid,
  output logic                outKind,
  output logic [LINE_W-1:0]   outLine,
  output logic [WIDX_W-1:0]   outWord,
  output logic [1:0]          outCode,
  output logic [WORDS-1:0]    outMask,
  output logic [WORDS*W-1:0]  outData
);
  logic [W-1:0]       lineBuf [LINES][WORDS];
  logic [LINE_W-1:0]  qLine   [DEPTH];
  logic [WORDS-1:0]   qMask   [DEPTH];
  logic [WORDS*W-1:0] qData   [DEPTH];
  logic [WORDS*W-1:0] merged;

  function automatic logic [1:0] encVal(logic [W-1:0] v);
    if (v == '0)            return CODE_ZERO;
    else if (v == W'(1))    return CODE_ONE;
    else if (v == {W{1'b1}}) return CODE_ONES;
    else                    return CODE_NONE;
  endfunction

  always_comb
    for (int w = 0; w < WORDS; w++)
      merged[w*W +: W] = !pushMask[w] ? '0 :
                         (stWord == WIDX_W'(w)) ? stData : lineBuf[stLine][w];

  always_ff @(posedge clk) begin
    if (stWrite) lineBuf[stLine][stWord] <= stData;
    if (strb.push) begin
      qLine[wrPtr] <= stLine;
      qMask[wrPtr] <= pushMask;
      qData[wrPtr] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outKind  <= KIND_INV;
      outLine  <= '0;
      outWord  <= '0;
      outCode  <= CODE_NONE;
      outMask  <= '0;
      outData  <= '0;
    end else if (strb.invSend) begin
      outValid <= 1'b1;
      outKind  <= KIND_INV;
      outLine  <= stLine;
      outWord  <= stWord;
      outCode  <= encVal(stData);
      outMask  <= '0;
      outData  <= '0;
    end else if (strb.pop) begin
      outValid <= 1'b1;
      outKind  <= KIND_UPD;
      outLine  <= qLine[rdPtr];
      outWord  <= '0;
      outCode  <= CODE_NONE;
      outMask  <= qMask[rdPtr];
      outData  <= qData[rdPtr];
    end else begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/spec_upd_rx.sv
module spec_upd_rx
  import spec_upd_pkg::*;
#(
  parameter int W      = 32,
  parameter int WORDS  = 4,
  parameter int LINE_W = 2,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inKind,
  input  logic [LINE_W-1:0]  inLine,
  input  logic [WIDX_W-1:0]  inWord,
  input  logic [1:0]         inCode,
  input  logic [WORDS-1:0]   inMask,
  input  logic [WORDS*W-1:0] inData,
  input  logic               cacheHit,
  input  logic               cacheInvalid,
  output logic               cacheWrEn,
  output logic [LINE_W-1:0]  cacheWrLine,
  output logic [WORDS-1:0]   cacheWrMask,
  output logic [WORDS*W-1:0] cacheWrData
);
  logic [W-1:0]       decoded;
  logic               wrNow;
  logic [WORDS-1:0]   maskNow;
  logic [WORDS*W-1:0] dataNow;

  always_comb begin
    unique case (inCode)
      CODE_ONE:  decoded = W'(1);
      CODE_ONES: decoded = {W{1'b1}};
      default:   decoded = '0;
    endcase
    if (inKind == KIND_INV) begin
      wrNow   = inValid && cacheHit && (inCode != CODE_NONE);
      maskNow = WORDS'(1) << inWord;
    end else begin
      wrNow   = inValid && cacheHit && cacheInvalid;
      maskNow = inMask;
    end
    for (int w = 0; w < WORDS; w++)
      dataNow[w*W +: W] = !maskNow[w] ? '0 :
                          (inKind == KIND_INV) ? decoded : inData[w*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheWrEn   <= 1'b0;
      cacheWrLine <= '0;
      cacheWrMask <= '0;
      cacheWrData <= '0;
    end else begin
      cacheWrEn <= wrNow;
      if (wrNow) begin
        cacheWrLine <= inLine;
        cacheWrMask <= maskNow;
        cacheWrData <= dataNow;
      end
    end
  end
endmodule

// File: rtl/spec_upd_top.sv
module spec_upd_top
  import spec_upd_pkg::*;
#(
  parameter int W      = 32,
  parameter int WORDS  = 4,
  parameter int LINE_W = 2,
  parameter int THRESH = 5,
  parameter int DEPTH  = 2,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stWrite,
  input  logic [LINE_W-1:0]  stLine,
  input  logic [WIDX_W-1:0]  stWord,
  input  logic [W-1:0]       stData,
  input  logic               stShared,
  input  logic               evValid,
  input  logic [LINE_W-1:0]  evLine,
  input  logic               updGrant,
  output logic               outValid,
  output logic               outKind,
  output logic [LINE_W-1:0]  outLine,
  output logic [WIDX_W-1:0]  outWord,
  output logic [1:0]         outCode,
  output logic [WORDS-1:0]   outMask,
  output logic [WORDS*W-1:0] outData,
  input  logic               inValid,
  input  logic               inKind,
  input  logic [LINE_W-1:0]  inLine,
  input  logic [WIDX_W-1:0]  inWord,
  input  logic [1:0]         inCode,
  input  logic [WORDS-1:0]   inMask,
  input  logic [WORDS*W-1:0] inData,
  output logic [LINE_W-1:0]  lookupLine,
  input  logic               cacheHit,
  input  logic               cacheInvalid,
  output logic               cacheWrEn,
  output logic [LINE_W-1:0]  cacheWrLine,
  output logic [WORDS-1:0]   cacheWrMask,
  output logic [WORDS*W-1:0] cacheWrData
);
  upd_strobe_t       strb;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [WORDS-1:0]  pushMask;
  logic              snoopInv;

  assign snoopInv   = inValid && (inKind == KIND_INV);
  assign lookupLine = inLine;

  spec_upd_ctrl #(.WORDS(WORDS), .LINE_W(LINE_W), .THRESH(THRESH), .DEPTH(DEPTH)) uCtrl (
    .clk, .rstN, .stWrite, .stLine, .stWord, .stShared, .evValid, .evLine,
    .snoopInv, .snoopLine(inLine), .updGrant, .strb, .wrPtr, .rdPtr, .pushMask
  );

  spec_upd_dp #(.W(W), .WORDS(WORDS), .LINE_W(LINE_W), .DEPTH(DEPTH)) uDp (
    .clk, .rstN, .strb, .wrPtr, .rdPtr, .pushMask, .stWrite, .stLine, .stWord, .stData,
    .outValid, .outKind, .outLine, .outWord, .outCode, .outMask, .outData
  );

  spec_upd_rx #(.W(W), .WORDS(WORDS), .LINE_W(LINE_W)) uRx (
    .clk, .rstN, .inValid, .inKind, .inLine, .inWord, .inCode, .inMask, .inData,
    .cacheHit, .cacheInvalid, .cacheWrEn, .cacheWrLine, .cacheWrMask, .cacheWrData
  );
endmodule

// File: rtl/spec_upd_chk.sv
module spec_upd_chk
  import spec_upd_pkg::*;
#(
  parameter int W      = 32,
  parameter int WORDS  = 4,
  parameter int LINE_W = 2,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              stWrite,
  input logic              stShared,
  input logic [LINE_W-1:0] stLine,
  input logic [WIDX_W-1:0] stWord,
  input logic [W-1:0]      stData,
  input logic              updGrant,
  input logic              outValid,
  input logic              outKind,
  input logic [LINE_W-1:0] outLine,
  input logic [WIDX_W-1:0] outWord,
  input logic [1:0]        outCode,
  input logic [WORDS-1:0]  outMask,
  input logic              inValid,
  input logic              inKind,
  input logic [1:0]        inCode,
  input logic              cacheHit,
  input logic              cacheInvalid,
  input logic              cacheWrEn
);
  // R2
  inv_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    stWrite && stShared |=> outValid && outKind == KIND_INV && outLine == $past(stLine)
                            && outWord == $past(stWord) && outMask == '0);

  // R2
  zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    stWrite && stShared && stData == '0 |=> outCode == CODE_ZERO);

  // R6
  upd_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outKind == KIND_UPD |-> $past(updGrant));

  // R4
  upd_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outKind == KIND_UPD |-> outMask != '0);

  // R8
  rx_nodata_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inKind == KIND_INV && inCode == CODE_NONE |=> !cacheWrEn);

  // R9
  rx_valid_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inKind == KIND_UPD && !(cacheHit && cacheInvalid) |=> !cacheWrEn);
endmodule

bind spec_upd_top spec_upd_chk #(.W(W), .WORDS(WORDS), .LINE_W(LINE_W)) uChk (
  .clk(clk), .rstN(rstN), .stWrite(stWrite), .stShared(stShared), .stLine(stLine),
  .stWord(stWord), .stData(stData), .updGrant(updGrant), .outValid(outValid),
  .outKind(outKind), .outLine(outLine), .outWord(outWord), .outCode(outCode),
  .outMask(outMask), .inValid(inValid), .inKind(inKind), .inCode(inCode),
  .cacheHit(cacheHit), .cacheInvalid(cacheInvalid), .cacheWrEn(cacheWrEn)
);

// File: tb/sim_spec_upd_top.sv
module sim_spec_upd_top;
  localparam int W = 32;
  localparam int WORDS = 4;
  localparam int LINE_W = 2;

  logic clk = 0;
  logic rstN = 0;
  logic stWrite = 0, stShared = 0, evValid = 0, updGrant = 0;
  logic [LINE_W-1:0] stLine = 0, evLine = 0, inLine = 0;
  logic [1:0] stWord = 0, inWord = 0;
  logic [W-1:0] stData = 0;
  logic outValid, outKind, cacheWrEn;
  logic [LINE_W-1:0] outLine, lookupLine, cacheWrLine;
  logic [1:0] outWord, outCode;
  logic [WORDS-1:0] outMask, cacheWrMask;
  logic [WORDS*W-1:0] outData, cacheWrData;
  logic inValid = 0, inKind = 0, cacheHit = 0, cacheInvalid = 0;
  logic [1:0] inCode = 0;
  logic [WORDS-1:0] inMask = 0;
  logic [WORDS*W-1:0] inData = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spec_upd_top u0 (.*);

  // store value, expected code
  localparam logic [33:0] ENC_VEC [6] = '{
    {32'h0000_0000, 2'b01}, {32'h0000_0001, 2'b10}, {32'hFFFF_FFFF, 2'b11},
    {32'h0000_0002, 2'b00}, {32'hFFFF_FFFE, 2'b00}, {32'h8000_0000, 2'b00}};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; tick(); tick(); rstN = 1;
  endtask

  task automatic store(input int line, input int word, input logic [W-1:0] d, input bit sh);
    stWrite = 1; stLine = LINE_W'(line); stWord = 2'(word); stData = d; stShared = sh;
    tick();
    stWrite = 0; stShared = 0;
  endtask

  task automatic rxMsg(input bit kind, input int line, input int word, input logic [1:0] code,
                       input logic [3:0] m, input bit hit, input bit inv);
    inValid = 1; inKind = kind; inLine = LINE_W'(line); inWord = 2'(word); inCode = code;
    inMask = m; cacheHit = hit; cacheInvalid = inv;
    inData = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
    tick();
    inValid = 0;
  endtask

  function automatic logic [135:0] upd(input int line, input logic [3:0] m, input logic [127:0] d);
    return {1'b1, 1'b1, 2'(line), m, d};
  endfunction

  function automatic logic [135:0] updAct();
    return {outValid, outKind, outLine, outMask, outData};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 outValid", outValid, 0);
    check("R1 cacheWrEn", cacheWrEn, 0);

    // R2 code table
    for (int i = 0; i < 6; i++) begin
      store(i % 4, i % 4, ENC_VEC[i][33:2], 1);
      check("R2 inv msg", {outValid, outKind, outLine, outWord, outMask, outCode},
            {1'b1, 1'b0, 2'(i % 4), 2'(i % 4), 4'b0, ENC_VEC[i][1:0]});
    end
    doReset();

    // R4 broadcast contents, R6 held without grant
    updGrant = 0;
    store(2, 0, 32'h11, 0); store(2, 2, 32'h22, 0); store(2, 0, 32'h33, 0);
    store(2, 3, 32'h44, 0); store(2, 2, 32'h55, 0);
    check("R6 held without grant", outValid, 0);
    updGrant = 1; tick();
    check("R4 broadcast", updAct(), upd(2, 4'b1101, {32'h44, 32'h55, 32'h0, 32'h33}));
    tick();
    check("R4 single broadcast", outValid, 0);

    // R5 clear on broadcast
    for (int k = 0; k < 4; k++) store(2, 1, 32'h60 + k, 0);
    tick();
    check("R5 count restarted", outValid, 0);
    store(2, 1, 32'h6F, 0); tick();
    check("R5 after broadcast", updAct(), upd(2, 4'b0010, {32'h0, 32'h0, 32'h6F, 32'h0}));

    // R5 clear on eviction
    for (int k = 0; k < 3; k++) store(1, 0, 32'h70, 0);
    evValid = 1; evLine = 1; tick(); evValid = 0;
    for (int k = 0; k < 4; k++) store(1, 3, 32'h71, 0);
    tick();
    check("R5 evict restarts count", outValid, 0);
    store(1, 3, 32'h72, 0); tick();
    check("R5 evict mask", updAct(), upd(1, 4'b1000, {32'h72, 32'h0, 32'h0, 32'h0}));

    // R5 clear on foreign invalidation
    for (int k = 0; k < 3; k++) store(3, 1, 32'h80, 0);
    rxMsg(0, 3, 0, 2'b00, 4'b0, 0, 0);
    for (int k = 0; k < 4; k++) store(3, 2, 32'h81, 0);
    tick();
    check("R5 snoop restarts count", outValid, 0);
    store(3, 2, 32'h82, 0); tick();
    check("R5 snoop mask", updAct(), upd(3, 4'b0100, {32'h0, 32'h82, 32'h0, 32'h0}));

    // R3 invalidation wins over ready broadcast
    for (int k = 0; k < 5; k++) store(0, 1, 32'h90, 0);
    store(1, 0, 32'h0, 1);
    check("R3 inv first", {outValid, outKind, outLine, outCode}, {1'b1, 1'b0, 2'd1, 2'b01});
    tick();
    check("R3 broadcast after", updAct(), upd(0, 4'b0010, {32'h0, 32'h0, 32'h90, 32'h0}));

    // R7 overflow drops oldest, R6 order
    updGrant = 0;
    for (int k = 0; k < 5; k++) store(0, 0, 32'hA0, 0);
    for (int k = 0; k < 5; k++) store(2, 1, 32'hB0, 0);
    for (int k = 0; k < 5; k++) store(3, 2, 32'hC0, 0);
    updGrant = 1; tick();
    check("R7 oldest dropped", updAct(), upd(2, 4'b0010, {32'h0, 32'h0, 32'hB0, 32'h0}));
    tick();
    check("R6 fifo order", updAct(), upd(3, 4'b0100, {32'h0, 32'hC0, 32'h0, 32'h0}));
    tick();
    check("R7 queue empty", outValid, 0);
    updGrant = 0;

    // R8 receiver piggyback
    inLine = 2; #1;
    check("R8 lookupLine", lookupLine, 2);
    rxMsg(0, 2, 2, 2'b10, 4'b0, 1, 0);
    check("R8 code 10", {cacheWrEn, cacheWrLine, cacheWrMask, cacheWrData},
          {1'b1, 2'd2, 4'b0100, 32'h0, 32'h1, 32'h0, 32'h0});
    rxMsg(0, 1, 0, 2'b11, 4'b0, 1, 1);
    check("R8 code 11", {cacheWrEn, cacheWrLine, cacheWrMask, cacheWrData},
          {1'b1, 2'd1, 4'b0001, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF});
    rxMsg(0, 3, 3, 2'b01, 4'b0, 1, 0);
    check("R8 code 01", {cacheWrEn, cacheWrMask, cacheWrData},
          {1'b1, 4'b1000, 128'h0});
    rxMsg(0, 3, 3, 2'b00, 4'b0, 1, 1);
    check("R8 code 00 no write", cacheWrEn, 0);
    rxMsg(0, 3, 3, 2'b10, 4'b0, 0, 1);
    check("R8 miss no write", cacheWrEn, 0);

    // R9 receiver broadcast
    rxMsg(1, 1, 0, 2'b00, 4'b1010, 1, 1);
    check("R9 invalid copy written", {cacheWrEn, cacheWrLine, cacheWrMask, cacheWrData},
          {1'b1, 2'd1, 4'b1010, 32'hDDDD_0003, 32'h0, 32'hBBBB_0001, 32'h0});
    rxMsg(1, 1, 0, 2'b00, 4'b1010, 1, 0);
    check("R9 valid copy dropped", cacheWrEn, 0);
    rxMsg(1, 1, 0, 2'b00, 4'b1010, 0, 1);
    check("R9 miss dropped", cacheWrEn, 0);

    // R1 reset mid-run
    store(0, 0, 32'h5, 1);
    rstN = 0; tick();
    check("R1 reset clears out", {outValid, cacheWrEn}, 2'b00);
    rstN = 1; tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule